// File: doc/BRIEF.md
# Floating-Point Control Register Access Gate

This block decides what happens when software tries to move a value to or from the floating-point exception control register. It takes the current privilege level (0 to 3) and the system configuration: which levels exist, which of them run in 32-bit mode, whether level 2 is enabled or running as a host, and the coprocessor-access and trap controls that several levels hold. It returns one outcome: the access is permitted, it is undefined, it traps to level 2 with a syndrome code, it takes a 32-bit hypervisor trap with a code, or it traps to level 3 with a code.

The checks run in a fixed priority order, and that order is different at each privilege level. A request is presented with a one-cycle `reqValid` strobe. The outcome is registered and appears on the response ports one clock later. Reads and writes are gated in exactly the same way. The direction is only carried through so the consumer can match the response to its request.

Top module: `fpAccessGate`

## Requirements
- R1: A request sampled with `reqValid` high at a rising edge produces `rspValid` high after that edge. `rspKind`, `rspCode` and `rspWrite` are loaded at that same edge. When `reqValid` is low, `rspValid` drops and the other response outputs hold their values. Reset clears all response outputs to 0.
- R2: The `rspKind` encoding is 0 for permit, 1 for undefined, 2 for trap to level 2, 3 for 32-bit hypervisor trap and 4 for trap to level 3. `rspCode` is 0x00 whenever the kind is permit or undefined.
- R3: Every access from level 0 (`curLevel` = 0) is undefined.
- R4: At level 1, the first check applies when level 3 exists, level 3 is 64-bit (`lvl3Narrow` = 0), `lvl3DbgPrio` = 1 and `lvl3FpTrap` = 1. The access is then undefined.
- R5: At level 1, the access is undefined next in either of two cases. The first is the non-secure restriction: level 3 exists, is 32-bit, `nonSecure` = 1 and `nsCopAllow` = 0. The second is `copAccess` = 2'b00.
- R6: At level 1, the access traps to level 2 with code 0x07 next in either of two cases. The first is level 2 enabled, 64-bit, not host and `lvl2FpTrap` = 1. The second is level 2 in host mode with bit 0 of `lvl2FpEnable` at 0. Bit 1 of `lvl2FpEnable` has no effect.
- R7: At level 1, the access takes a hypervisor trap with code 0x08 next when level 2 is enabled and 32-bit, and either the non-secure restriction holds or `hypCopTrap` = 1.
- R8: At level 1, the last check applies when level 3 exists, is 64-bit and `lvl3FpTrap` = 1. The access is then undefined if `lvl3DbgUndef` = 1, and traps to level 3 with code 0x07 otherwise. If no check fires, the access is permitted.
- R9: At level 2, the checks run in this order: the level-3 priority undefined check of R4, the host-mode enable trap of R6 (code 0x07), a hypervisor trap with code 0x00 (level 2 enabled and either the non-secure restriction or `hypCopTrap`), and the level-3 check of R8. `copAccess` and `lvl2FpTrap` are not examined at level 2.
- R10: At level 3, the access is undefined exactly when `copAccess` = 2'b00, and permitted otherwise.
- R11: `isWrite` does not change `rspKind` or `rspCode`. It is returned unchanged on `rspWrite`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| isWrite | input | 1 | 1 = write to the register, 0 = read |
| curLevel | input | 2 | Current privilege level |
| lvl3Exists | input | 1 | Level 3 is implemented |
| lvl3Narrow | input | 1 | Level 3 runs in 32-bit mode |
| lvl2On | input | 1 | Level 2 is enabled |
| lvl2Narrow | input | 1 | Level 2 runs in 32-bit mode |
| lvl2Host | input | 1 | Level 2 is in host mode |
| nonSecure | input | 1 | Non-secure state bit |
| nsCopAllow | input | 1 | Non-secure access allowance for the FP coprocessor |
| copAccess | input | 2 | FP coprocessor access field of level 1 |
| lvl3FpTrap | input | 1 | Level-3 FP trap control |
| lvl2FpTrap | input | 1 | Level-2 FP trap control (non-host) |
| lvl2FpEnable | input | 2 | Level-2 FP enable field (host mode) |
| hypCopTrap | input | 1 | 32-bit hypervisor FP coprocessor trap |
| lvl3DbgPrio | input | 1 | Secure-debug-disabled priority undefined condition |
| lvl3DbgUndef | input | 1 | Secure-debug-disabled undefined condition |
| rspValid | output | 1 | Response strobe |
| rspKind | output | 3 | Outcome kind |
| rspCode | output | 8 | Syndrome code |
| rspWrite | output | 1 | Direction of the answered request |

## Verification
The main pattern is a sweep that sends every combination of privilege level and control bit, one request per clock, back to back. Each response is compared against an independent priority model. The model reports which rule decided the outcome, so a mismatch identifies the rule whose ordering or code is wrong. This includes a level-2 trap code where 0x00 belongs, or a level-1 field leaking into level-2 checks. Directed patterns cover the rest. Identical controls sent with both directions show that direction is neutral. Toggling only the upper enable bit separates the host-trap bit from its neighbour. Dropping the strobe while the controls change shows that outputs hold between requests.

// File: rtl/fpAccessGate_pkg.sv
package fpAccessGate_pkg;

  parameter int KIND_W = 3;
  parameter int CODE_W = 8;

  typedef enum logic [KIND_W-1:0] {
    KIND_PERMIT   = 3'd0,
    KIND_UNDEF    = 3'd1,
    KIND_TRAP_L2  = 3'd2,
    KIND_HYP_TRAP = 3'd3,
    KIND_TRAP_L3  = 3'd4
  } accessKind_t;

  // Strobes from the control decode to the datapath registers
  typedef struct packed {
    logic capture;     // load response this cycle
    logic dirWrite;    // direction of the request
    logic hitUndef;
    logic hitTrapL2;
    logic hitHyp;
    logic hitTrapL3;
    logic hypFromL2;   // hypervisor trap raised from level 2
  } gateStrobe_t;

  // Control inputs grouped for the internal decode
  typedef struct packed {
    logic       lvl3Exists;
    logic       lvl3Narrow;
    logic       lvl2On;
    logic       lvl2Narrow;
    logic       lvl2Host;
    logic       nonSecure;
    logic       nsCopAllow;
    logic [1:0] copAccess;
    logic       lvl3FpTrap;
    logic       lvl2FpTrap;
    logic [1:0] lvl2FpEnable;
    logic       hypCopTrap;
    logic       lvl3DbgPrio;
    logic       lvl3DbgUndef;
  } gateCfg_t;

endpackage

// File: rtl/fpAccessGate_ctrl.sv
module fpAccessGate_ctrl
  import fpAccessGate_pkg::*;
#(
  parameter int LEVEL_W = 2
) (
  input  logic               reqValid,
  input  logic               isWrite,
  input  logic [LEVEL_W-1:0] curLevel,
  input  gateCfg_t           cfg,
  output gateStrobe_t        strobe
);

  localparam int NUM_LEVELS = 1 << LEVEL_W;

  // Shared conditions
  logic lvl3Wide;
  logic nsRestrict;
  logic lvl3PrioUndef;
  logic hostFpOff;
  logic lvl3TrapOn;
  logic copDenied;

  always_comb begin
    lvl3Wide      = cfg.lvl3Exists & ~cfg.lvl3Narrow;
    nsRestrict    = cfg.lvl3Exists & cfg.lvl3Narrow & cfg.nonSecure & ~cfg.nsCopAllow;
    lvl3PrioUndef = lvl3Wide & cfg.lvl3DbgPrio & cfg.lvl3FpTrap;
    hostFpOff     = cfg.lvl2Host & ~cfg.lvl2FpEnable[0];
    lvl3TrapOn    = lvl3Wide & cfg.lvl3FpTrap;
    copDenied     = (cfg.copAccess == 2'b00);
  end

  // Per-level outcome vectors: {undef, trapL2, hyp, trapL3}
  logic [3:0] levelHit [NUM_LEVELS];

  // Level 1 chain
  logic l1Stage2Undef;
  logic l1Lvl2Trap;
  logic l1Hyp;
  logic [3:0] l1Vec;

  always_comb begin
    l1Stage2Undef = nsRestrict | copDenied;
    l1Lvl2Trap    = (cfg.lvl2On & ~cfg.lvl2Narrow & ~cfg.lvl2Host & cfg.lvl2FpTrap) | hostFpOff;
    l1Hyp         = cfg.lvl2On & cfg.lvl2Narrow & (nsRestrict | cfg.hypCopTrap);
    l1Vec         = 4'b0000;
    if (lvl3PrioUndef)       l1Vec = 4'b1000;
    else if (l1Stage2Undef)  l1Vec = 4'b1000;
    else if (l1Lvl2Trap)     l1Vec = 4'b0100;
    else if (l1Hyp)          l1Vec = 4'b0010;
    else if (lvl3TrapOn)     l1Vec = cfg.lvl3DbgUndef ? 4'b1000 : 4'b0001;
  end

  // Level 2 chain
  logic l2Hyp;
  logic [3:0] l2Vec;

  always_comb begin
    l2Hyp = cfg.lvl2On & (nsRestrict | cfg.hypCopTrap);
    l2Vec = 4'b0000;
    if (lvl3PrioUndef)   l2Vec = 4'b1000;
    else if (hostFpOff)  l2Vec = 4'b0100;
    else if (l2Hyp)      l2Vec = 4'b0010;
    else if (lvl3TrapOn) l2Vec = cfg.lvl3DbgUndef ? 4'b1000 : 4'b0001;
  end

  // Assign each level its vector
  genvar lv;
  generate
    for (lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
      if (lv == 0) begin : g_l0
        assign levelHit[lv] = 4'b1000;
      end else if (lv == 1) begin : g_l1
        assign levelHit[lv] = l1Vec;
      end else if (lv == 2) begin : g_l2
        assign levelHit[lv] = l2Vec;
      end else begin : g_l3
        assign levelHit[lv] = {copDenied, 3'b000};
      end
    end
  endgenerate

  logic [3:0] selVec;
  always_comb begin
    selVec             = levelHit[curLevel];
    strobe.capture     = reqValid;
    strobe.dirWrite    = isWrite;
    strobe.hitUndef    = selVec[3];
    strobe.hitTrapL2   = selVec[2];
    strobe.hitHyp      = selVec[1];
    strobe.hitTrapL3   = selVec[0];
    strobe.hypFromL2   = (curLevel == LEVEL_W'(2));
  end

endmodule

// File: rtl/fpAccessGate_dp.sv
module fpAccessGate_dp
  import fpAccessGate_pkg::*;
#(
  parameter logic [CODE_W-1:0] TRAP_CODE   = 8'h07,
  parameter logic [CODE_W-1:0] HYP_CODE_L1 = 8'h08,
  parameter logic [CODE_W-1:0] HYP_CODE_L2 = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  output logic              rspValid,
  output logic [KIND_W-1:0] rspKind,
  output logic [CODE_W-1:0] rspCode,
  output logic              rspWrite
);

  accessKind_t       nextKind;
  logic [CODE_W-1:0] nextCode;

  always_comb begin
    nextKind = KIND_PERMIT;
    nextCode = '0;
    if (strobe.hitUndef) begin
      nextKind = KIND_UNDEF;
    end else if (strobe.hitTrapL2) begin
      nextKind = KIND_TRAP_L2;
      nextCode = TRAP_CODE;
    end else if (strobe.hitHyp) begin
      nextKind = KIND_HYP_TRAP;
      nextCode = strobe.hypFromL2 ? HYP_CODE_L2 : HYP_CODE_L1;
    end else if (strobe.hitTrapL3) begin
      nextKind = KIND_TRAP_L3;
      nextCode = TRAP_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspKind  <= '0;
      rspCode  <= '0;
      rspWrite <= 1'b0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) begin
        rspKind  <= nextKind;
        rspCode  <= nextCode;
        rspWrite <= strobe.dirWrite;
      end
    end
  end

endmodule

// File: rtl/fpAccessGate.sv
module fpAccessGate
  import fpAccessGate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       isWrite,
  input  logic [1:0] curLevel,
  input  logic       lvl3Exists,
  input  logic       lvl3Narrow,
  input  logic       lvl2On,
  input  logic       lvl2Narrow,
  input  logic       lvl2Host,
  input  logic       nonSecure,
  input  logic       nsCopAllow,
  input  logic [1:0] copAccess,
  input  logic       lvl3FpTrap,
  input  logic       lvl2FpTrap,
  input  logic [1:0] lvl2FpEnable,
  input  logic       hypCopTrap,
  input  logic       lvl3DbgPrio,
  input  logic       lvl3DbgUndef,
  output logic       rspValid,
  output logic [2:0] rspKind,
  output logic [7:0] rspCode,
  output logic       rspWrite
);

  gateCfg_t    cfg;
  gateStrobe_t strobe;

  always_comb begin
    cfg.lvl3Exists   = lvl3Exists;
    cfg.lvl3Narrow   = lvl3Narrow;
    cfg.lvl2On       = lvl2On;
    cfg.lvl2Narrow   = lvl2Narrow;
    cfg.lvl2Host     = lvl2Host;
    cfg.nonSecure    = nonSecure;
    cfg.nsCopAllow   = nsCopAllow;
    cfg.copAccess    = copAccess;
    cfg.lvl3FpTrap   = lvl3FpTrap;
    cfg.lvl2FpTrap   = lvl2FpTrap;
    cfg.lvl2FpEnable = lvl2FpEnable;
    cfg.hypCopTrap   = hypCopTrap;
    cfg.lvl3DbgPrio  = lvl3DbgPrio;
    cfg.lvl3DbgUndef = lvl3DbgUndef;
  end

  fpAccessGate_ctrl #(.LEVEL_W(2)) u_ctrl (
    .reqValid (reqValid),
    .isWrite  (isWrite),
    .curLevel (curLevel),
    .cfg      (cfg),
    .strobe   (strobe)
  );

  fpAccessGate_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rspValid (rspValid),
    .rspKind  (rspKind),
    .rspCode  (rspCode),
    .rspWrite (rspWrite)
  );

endmodule

// File: rtl/fpAccessGate_chk.sv
module fpAccessGate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       isWrite,
  input logic [1:0] curLevel,
  input logic       lvl3Exists,
  input logic       lvl3Narrow,
  input logic [1:0] copAccess,
  input logic       lvl3FpTrap,
  input logic       lvl3DbgPrio,
  input logic       rspValid,
  input logic [2:0] rspKind,
  input logic [7:0] rspCode,
  input logic       rspWrite
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && $stable(rspKind) && $stable(rspCode)));

  assert_code_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspKind == 3'd0 || rspKind == 3'd1)) |-> (rspCode == 8'h00));

  assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspKind <= 3'd4));

  assert_level0_undef_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curLevel == 2'd0) |=> (rspKind == 3'd1));

  assert_prio_undef_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curLevel == 2'd1 && lvl3Exists && !lvl3Narrow && lvl3DbgPrio && lvl3FpTrap)
      |=> (rspKind == 3'd1));

  assert_level3_rule_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curLevel == 2'd3)
      |=> (rspKind == (($past(copAccess) == 2'b00) ? 3'd1 : 3'd0)));

  assert_dir_echo_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspWrite == $past(isWrite)));

endmodule

bind fpAccessGate fpAccessGate_chk u_chk (.*);

// File: tb/fpAccessGate_bench.sv
`timescale 1ns/1ps
module fpAccessGate_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid;
  logic       isWrite;
  logic [1:0] curLevel;
  logic       lvl3Exists, lvl3Narrow, lvl2On, lvl2Narrow, lvl2Host;
  logic       nonSecure, nsCopAllow;
  logic [1:0] copAccess;
  logic       lvl3FpTrap, lvl2FpTrap;
  logic [1:0] lvl2FpEnable;
  logic       hypCopTrap, lvl3DbgPrio, lvl3DbgUndef;
  logic       rspValid;
  logic [2:0] rspKind;
  logic [7:0] rspCode;
  logic       rspWrite;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fpAccessGate u_fpAccessGate (.*);

  // Vector layout: [1:0] level, 2 lvl3Exists, 3 lvl3Narrow, 4 lvl2On, 5 lvl2Narrow,
  // 6 lvl2Host, 7 nonSecure, 8 nsCopAllow, [10:9] copAccess, 11 lvl3FpTrap,
  // 12 lvl2FpTrap, 13 lvl2FpEnable[0], 14 hypCopTrap, 15 lvl3DbgPrio, 16 lvl3DbgUndef
  task automatic driveReq(input logic [16:0] v, input logic enHi, input logic wr);
    reqValid     = 1'b1;
    isWrite      = wr;
    curLevel     = v[1:0];
    lvl3Exists   = v[2];
    lvl3Narrow   = v[3];
    lvl2On       = v[4];
    lvl2Narrow   = v[5];
    lvl2Host     = v[6];
    nonSecure    = v[7];
    nsCopAllow   = v[8];
    copAccess    = v[10:9];
    lvl3FpTrap   = v[11];
    lvl2FpTrap   = v[12];
    lvl2FpEnable = {enHi, v[13]};
    hypCopTrap   = v[14];
    lvl3DbgPrio  = v[15];
    lvl3DbgUndef = v[16];
  endtask

  // Independent priority model built from the requirements
  function automatic void model(input logic [16:0] v, output logic [2:0] k,
                                output logic [7:0] c, output string tag);
    logic wide3, nsR, host0;
    wide3 = v[2] & ~v[3];
    nsR   = v[2] & v[3] & v[7] & ~v[8];
    host0 = v[6] & ~v[13];
    k = 3'd0; c = 8'h00;
    case (v[1:0])
      2'd0: begin k = 3'd1; tag = "R3"; end
      2'd1: begin
        if (wide3 && v[15] && v[11]) begin k = 3'd1; tag = "R4"; end
        else if (nsR || v[10:9] == 2'b00) begin k = 3'd1; tag = "R5"; end
        else if (v[4] && !v[5] && !v[6] && v[12]) begin k = 3'd2; c = 8'h07; tag = "R6"; end
        else if (host0) begin k = 3'd2; c = 8'h07; tag = "R6"; end
        else if (v[4] && v[5] && (nsR || v[14])) begin k = 3'd3; c = 8'h08; tag = "R7"; end
        else if (wide3 && v[11]) begin
          tag = "R8";
          if (v[16]) k = 3'd1; else begin k = 3'd4; c = 8'h07; end
        end else tag = "R8";
      end
      2'd2: begin
        tag = "R9";
        if (wide3 && v[15] && v[11]) k = 3'd1;
        else if (host0) begin k = 3'd2; c = 8'h07; end
        else if (v[4] && (nsR || v[14])) begin k = 3'd3; c = 8'h00; end
        else if (wide3 && v[11]) begin
          if (v[16]) k = 3'd1; else begin k = 3'd4; c = 8'h07; end
        end
      end
      default: begin tag = "R10"; k = (v[10:9] == 2'b00) ? 3'd1 : 3'd0; end
    endcase
  endfunction

  task automatic checkResp(input string tag, input logic [2:0] ek, input logic [7:0] ec,
                           input logic ew);
    checks++;
    if (rspValid !== 1'b1 || rspKind !== ek || rspCode !== ec || rspWrite !== ew) begin
      errors++;
      $display("FAIL %s: valid=%b kind=%0d code=%02h wr=%b expected valid=1 kind=%0d code=%02h wr=%b",
               tag, rspValid, rspKind, rspCode, rspWrite, ek, ec, ew);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || rspKind !== 3'd0 || rspCode !== 8'h00 || rspWrite !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset state valid=%b kind=%0d code=%02h wr=%b expected all 0",
               rspValid, rspKind, rspCode, rspWrite);
    end
  endtask

  // Full sweep, one request per clock, pipelined checking
  task automatic testSweep();
    logic [2:0] ek; logic [7:0] ec; string tag; logic ew;
    logic [16:0] prev;
    logic prevW;
    prev = '0; prevW = 1'b0;
    for (int i = 0; i < (1 << 17); i++) begin
      @(negedge clk);
      if (i > 0) begin
        model(prev, ek, ec, tag);
        checkResp(tag, ek, ec, prevW);
      end
      prev  = 17'(i);
      prevW = prev[0] ^ prev[5] ^ prev[9];
      driveReq(prev, prev[16] ^ prev[2], prevW);
    end
    @(negedge clk);
    reqValid = 1'b0;
    model(prev, ek, ec, tag);
    checkResp(tag, ek, ec, prevW);
  endtask

  // R1: outputs hold while no request arrives
  task automatic testHold();
    logic [16:0] v;
    v = '0; v[1:0] = 2'd1; v[10:9] = 2'b11; v[6] = 1'b1; // host, enable bit 0 clear -> trap
    @(negedge clk); driveReq(v, 1'b0, 1'b1);
    @(negedge clk); reqValid = 1'b0;
    checkResp("R1", 3'd2, 8'h07, 1'b1);
    curLevel = 2'd0; isWrite = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || rspKind !== 3'd2 || rspCode !== 8'h07 || rspWrite !== 1'b1) begin
      errors++;
      $display("FAIL R1: hold valid=%b kind=%0d code=%02h wr=%b expected valid=0 kind=2 code=07 wr=1",
               rspValid, rspKind, rspCode, rspWrite);
    end
  endtask

  // R11: both directions give the same outcome
  task automatic testDirection();
    logic [16:0] v;
    logic [2:0] ek; logic [7:0] ec; string tag;
    for (int j = 0; j < 4; j++) begin
      v = '0; v[1:0] = 2'(j); v[10:9] = 2'b01; v[4] = 1'b1; v[5] = 1'b1; v[14] = 1'b1;
      model(v, ek, ec, tag);
      for (int w = 0; w < 2; w++) begin
        @(negedge clk); driveReq(v, 1'b0, w[0]);
        @(negedge clk); reqValid = 1'b0;
        checkResp("R11", ek, ec, w[0]);
      end
    end
  endtask

  // R6: only bit 0 of the host enable field matters
  task automatic testEnableHigh();
    logic [16:0] v;
    v = '0; v[1:0] = 2'd1; v[6] = 1'b1; v[10:9] = 2'b11;
    @(negedge clk); driveReq(v, 1'b1, 1'b0);
    @(negedge clk); reqValid = 1'b0;
    checkResp("R6", 3'd2, 8'h07, 1'b0);
    v[13] = 1'b1;
    @(negedge clk); driveReq(v, 1'b0, 1'b0);
    @(negedge clk); reqValid = 1'b0;
    checkResp("R6", 3'd0, 8'h00, 1'b0);
  endtask

  initial begin
    rstN = 1'b0;
    driveReq('0, 1'b0, 1'b0);
    reqValid = 1'b0;
    repeat (3) @(posedge clk);
    testReset();
    rstN = 1'b1;
    testHold();
    testDirection();
    testEnableHigh();
    testSweep();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule